// File: doc/BRIEF.md
# Corrected-Error Interrupt Signaling Unit

This unit keeps one corrected-error tally per memory module and raises a host interrupt when a tally climbs above a programmable threshold. A second source of trouble, the loss of redundancy after an uncorrectable error on one side of a mirrored channel pair, raises the same interrupt and records which module failed. Two interrupt lines are provided: a system-management style line and a non-maskable style line. Each has its own enable, and normally only one of them is set.

Both causes are held as separate sticky status. Host software may service one cause while the other is still set. The interrupt line then stays up until every cause is gone. An overflow bit can only be dropped by clearing its own tally.

The interrupt control is a three-state machine. The states are QUIET (no cause pending), HELD (a cause is pending but no enable is set) and SIGNAL (a cause is pending and at least one enable is set). Each cycle the next state is chosen from the current causes and enables. No cause leads to QUIET. A cause with no enable leads to HELD. A cause with an enable leads to SIGNAL. This choice is the same from any state, so every transition between the three states can occur. An interrupt line is high only in SIGNAL, and only while its own enable is set.

Top module: `cerr_irq_unit`

## Requirements
- R1: After reset all tallies read zero, the overflow bitmap and the redundancy-loss flag are zero, the failed-module index is zero, both interrupt lines are low, the threshold is all-ones and both enables are clear.
- R2: A corrected-error pulse with module index i adds one to tally i. The new value is readable on `cnt_value`, with `cnt_sel` = i, after the next clock edge. Other tallies are unchanged.
- R3: A tally saturates at all-ones and does not wrap.
- R4: Overflow bit i sets on the clock edge after tally i is strictly greater than the threshold. This also happens when the threshold is lowered below an existing tally. The bit stays set when the threshold is later raised.
- R5: A configuration write to address 2 clears, on that edge, the tally and the overflow bit of every module whose data bit is 1 (bit i selects module i).
- R6: When a clear of a tally and a corrected error for the same module arrive in the same cycle, the tally reads zero after that edge. The error is then counted on the following edge, so the tally reads one.
- R7: An uncorrectable mirrored-channel event sets `redund_lost` and loads the event's module index into `failed_dimm` on the same edge.
- R8: A write to address 3 with data bit 0 set clears `redund_lost`. If a new loss event arrives in the same cycle, the flag stays set.
- R9: With enable bit 0 set at address 1, `smi_irq` goes high one edge after a cause bit becomes visible. Enable bit 1 does the same for `nmi_irq`. With both bits set, both lines are high.
- R10: While both causes are pending, clearing only one of them leaves the enabled interrupt line high.
- R11: With both enables clear, a pending cause raises no line. Setting an enable later raises its line one edge after the enable write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_valid | input | 1 | Corrected-error pulse |
| ce_dimm | input | 3 | Module index of the corrected error |
| ue_mirror_valid | input | 1 | Uncorrectable error on a mirrored channel (redundancy lost) |
| ue_dimm | input | 3 | Module index of the failed module |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0 threshold, 1 enables, 2 tally clear mask, 3 status clear |
| cfg_wdata | input | 16 | Write data |
| cnt_sel | input | 3 | Tally selected for readback |
| cnt_value | output | 16 | Selected tally value |
| ovf_map | output | 8 | Overflow bit per module |
| redund_lost | output | 1 | Redundancy-loss flag |
| failed_dimm | output | 3 | Module index recorded at the last loss event |
| smi_irq | output | 1 | System-management style interrupt level |
| nmi_irq | output | 1 | Non-maskable style interrupt level |

## Verification
Each result has a fixed latency. A tally, a clear or the loss flag shows the change after the edge that samples the stimulus. An overflow bit follows one edge after its tally. The interrupt line follows one edge after the cause bit. An enable change takes effect one edge after the write. The bench drives and samples on falling edges. It waits exactly that many falling edges before each check, and for the race cases it checks both the clearing edge and the edge after it.

// File: rtl/cerr_pkg.sv
package cerr_pkg;
    localparam logic [1:0] ADDR_THRESH   = 2'd0;
    localparam logic [1:0] ADDR_ENABLE   = 2'd1;
    localparam logic [1:0] ADDR_CNT_CLR  = 2'd2;
    localparam logic [1:0] ADDR_STAT_CLR = 2'd3;

    typedef enum logic [1:0] {
        ST_QUIET  = 2'd0,
        ST_HELD   = 2'd1,
        ST_SIGNAL = 2'd2
    } irq_state_t;
endpackage

// File: rtl/cerr_counter_bank.sv
module cerr_counter_bank #(
    parameter int NUM_DIMMS = 8,
    parameter int CNT_W     = 16,
    localparam int IDX_W    = $clog2(NUM_DIMMS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       inc_valid,
    input  logic [IDX_W-1:0]           inc_idx,
    input  logic [NUM_DIMMS-1:0]       clr_mask,
    input  logic [CNT_W-1:0]           threshold,
    output logic [NUM_DIMMS*CNT_W-1:0] cnt_flat,
    output logic [NUM_DIMMS-1:0]       ovf_map
);
    for (genvar i = 0; i < NUM_DIMMS; i++) begin : g_cnt
        logic [CNT_W-1:0] cnt_q;
        logic             defer_q;
        logic             ovf_q;
        logic             hit;
        logic [CNT_W:0]   sum;
        logic [CNT_W-1:0] cnt_next;

        assign hit = inc_valid && (inc_idx == IDX_W'(i));

        always_comb begin
            sum      = {1'b0, cnt_q} + (CNT_W+1)'(defer_q) + (CNT_W+1)'(hit);
            cnt_next = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q   <= '0;
                defer_q <= 1'b0;
                ovf_q   <= 1'b0;
            end else if (clr_mask[i]) begin
                cnt_q   <= '0;
                ovf_q   <= 1'b0;
                defer_q <= hit;
            end else begin
                cnt_q   <= cnt_next;
                defer_q <= 1'b0;
                ovf_q   <= ovf_q | (cnt_q > threshold);
            end
        end

        assign cnt_flat[i*CNT_W +: CNT_W] = cnt_q;
        assign ovf_map[i]                 = ovf_q;
    end
endmodule

// File: rtl/cerr_redund_tracker.sv
module cerr_redund_tracker #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loss_valid,
    input  logic [IDX_W-1:0] loss_idx,
    input  logic             flag_clr,
    output logic             flag,
    output logic [IDX_W-1:0] idx
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
            idx  <= '0;
        end else if (loss_valid) begin
            flag <= 1'b1;
            idx  <= loss_idx;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/cerr_irq_fsm.sv
module cerr_irq_fsm
    import cerr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cause,
    input  logic [1:0] enable,
    output logic       smi_irq,
    output logic       nmi_irq
);
    irq_state_t state_q;
    irq_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        if (!cause)           state_d = ST_QUIET;
        else if (|enable)     state_d = ST_SIGNAL;
        else                  state_d = ST_HELD;
    end

    always_comb begin
        smi_irq = 1'b0;
        nmi_irq = 1'b0;
        unique case (state_q)
            ST_QUIET:  ;
            ST_HELD:   ;
            ST_SIGNAL: begin
                smi_irq = enable[0];
                nmi_irq = enable[1];
            end
            default:   ;
        endcase
    end
endmodule

// File: rtl/cerr_irq_unit.sv
module cerr_irq_unit
    import cerr_pkg::*;
#(
    parameter int NUM_DIMMS = 8,
    parameter int CNT_W     = 16,
    localparam int IDX_W    = $clog2(NUM_DIMMS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ce_valid,
    input  logic [IDX_W-1:0]     ce_dimm,
    input  logic                 ue_mirror_valid,
    input  logic [IDX_W-1:0]     ue_dimm,
    input  logic                 cfg_wr_en,
    input  logic [1:0]           cfg_addr,
    input  logic [CNT_W-1:0]     cfg_wdata,
    input  logic [IDX_W-1:0]     cnt_sel,
    output logic [CNT_W-1:0]     cnt_value,
    output logic [NUM_DIMMS-1:0] ovf_map,
    output logic                 redund_lost,
    output logic [IDX_W-1:0]     failed_dimm,
    output logic                 smi_irq,
    output logic                 nmi_irq
);
    logic [CNT_W-1:0]           thresh_q;
    logic [1:0]                 en_q;
    logic [NUM_DIMMS-1:0]       clr_mask;
    logic                       flag_clr;
    logic [NUM_DIMMS*CNT_W-1:0] cnt_flat;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thresh_q <= '1;
            en_q     <= 2'b00;
        end else if (cfg_wr_en) begin
            if (cfg_addr == ADDR_THRESH) thresh_q <= cfg_wdata;
            if (cfg_addr == ADDR_ENABLE) en_q     <= cfg_wdata[1:0];
        end
    end

    assign clr_mask = (cfg_wr_en && cfg_addr == ADDR_CNT_CLR) ? cfg_wdata[NUM_DIMMS-1:0] : '0;
    assign flag_clr = cfg_wr_en && (cfg_addr == ADDR_STAT_CLR) && cfg_wdata[0];

    cerr_counter_bank #(.NUM_DIMMS(NUM_DIMMS), .CNT_W(CNT_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_valid (ce_valid),
        .inc_idx   (ce_dimm),
        .clr_mask  (clr_mask),
        .threshold (thresh_q),
        .cnt_flat  (cnt_flat),
        .ovf_map   (ovf_map)
    );

    cerr_redund_tracker #(.IDX_W(IDX_W)) u_redund (
        .clk        (clk),
        .rst_n      (rst_n),
        .loss_valid (ue_mirror_valid),
        .loss_idx   (ue_dimm),
        .flag_clr   (flag_clr),
        .flag       (redund_lost),
        .idx        (failed_dimm)
    );

    cerr_irq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cause   ((|ovf_map) | redund_lost),
        .enable  (en_q),
        .smi_irq (smi_irq),
        .nmi_irq (nmi_irq)
    );

    assign cnt_value = cnt_flat[cnt_sel*CNT_W +: CNT_W];
endmodule

// File: rtl/cerr_irq_checker.sv
module cerr_irq_checker #(
    parameter int NUM_DIMMS = 8,
    parameter int CNT_W     = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 smi_irq,
    input logic                 nmi_irq,
    input logic [NUM_DIMMS-1:0] ovf_map,
    input logic                 redund_lost,
    input logic                 ue_mirror_valid,
    input logic                 cfg_wr_en,
    input logic [1:0]           cfg_addr,
    input logic [CNT_W-1:0]     cfg_wdata
);
    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_irq || nmi_irq) |-> $past((|ovf_map) || redund_lost)); // R9

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(ovf_map) & ~ovf_map)) |-> $past(cfg_wr_en && cfg_addr == 2'd2)); // R4

    AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_addr == 2'd2) |=> ((ovf_map & $past(cfg_wdata[NUM_DIMMS-1:0])) == '0)); // R5

    AST_REDUND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ue_mirror_valid |=> redund_lost); // R7

    AST_REDUND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (redund_lost && !(cfg_wr_en && cfg_addr == 2'd3 && cfg_wdata[0])) |=> redund_lost); // R8
endmodule

bind cerr_irq_unit cerr_irq_checker #(.NUM_DIMMS(NUM_DIMMS), .CNT_W(CNT_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .smi_irq         (smi_irq),
    .nmi_irq         (nmi_irq),
    .ovf_map         (ovf_map),
    .redund_lost     (redund_lost),
    .ue_mirror_valid (ue_mirror_valid),
    .cfg_wr_en       (cfg_wr_en),
    .cfg_addr        (cfg_addr),
    .cfg_wdata       (cfg_wdata)
);

// File: tb/tb_cerr_irq_unit.sv
`timescale 1ns/1ps
module tb_cerr_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_valid = 1'b0;
    logic [2:0]  ce_dimm = '0;
    logic        ue_mirror_valid = 1'b0;
    logic [2:0]  ue_dimm = '0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [2:0]  cnt_sel = '0;
    logic [15:0] cnt_value;
    logic [7:0]  ovf_map;
    logic        redund_lost;
    logic [2:0]  failed_dimm;
    logic        smi_irq;
    logic        nmi_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cerr_irq_unit dut (
        .clk(clk), .rst_n(rst_n), .ce_valid(ce_valid), .ce_dimm(ce_dimm),
        .ue_mirror_valid(ue_mirror_valid), .ue_dimm(ue_dimm),
        .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cnt_sel(cnt_sel), .cnt_value(cnt_value), .ovf_map(ovf_map),
        .redund_lost(redund_lost), .failed_dimm(failed_dimm),
        .smi_irq(smi_irq), .nmi_irq(nmi_irq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic ce_pulse(input logic [2:0] idx);
        ce_valid = 1'b1; ce_dimm = idx;
        @(negedge clk);
        ce_valid = 1'b0;
    endtask

    task automatic ue_pulse(input logic [2:0] idx);
        ue_mirror_valid = 1'b1; ue_dimm = idx;
        @(negedge clk);
        ue_mirror_valid = 1'b0;
    endtask

    task automatic read_cnt(input string req, input logic [2:0] idx, input int exp);
        cnt_sel = idx;
        #1;
        chk(req, $sformatf("tally %0d", idx), int'(cnt_value), exp);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 8; i++) read_cnt("R1", 3'(i), 0);
        chk("R1", "ovf_map", int'(ovf_map), 0);
        chk("R1", "redund_lost", int'(redund_lost), 0);
        chk("R1", "failed_dimm", int'(failed_dimm), 0);
        chk("R1", "smi_irq", int'(smi_irq), 0);
        chk("R1", "nmi_irq", int'(nmi_irq), 0);
    endtask

    task automatic t_count();
        cfg_write(2'd0, 16'd3);
        cfg_write(2'd1, 16'd1);
        for (int i = 0; i < 3; i++) ce_pulse(3'd2);
        read_cnt("R2", 3'd2, 3);
        read_cnt("R2", 3'd1, 0);
        step(1);
        chk("R4", "ovf at threshold", int'(ovf_map), 0);
        ce_pulse(3'd2);
        read_cnt("R2", 3'd2, 4);
        chk("R4", "ovf not yet", int'(ovf_map), 0);
        step(1);
        chk("R4", "ovf set", int'(ovf_map), 8'h04);
        chk("R9", "smi before latency", int'(smi_irq), 0);
        step(1);
        chk("R9", "smi raised", int'(smi_irq), 1);
        chk("R9", "nmi stays low", int'(nmi_irq), 0);
    endtask

    task automatic t_thresh_raise();
        cfg_write(2'd0, 16'hFFFF);
        step(1);
        chk("R4", "ovf sticky after raise", int'(ovf_map), 8'h04);
        chk("R9", "smi held", int'(smi_irq), 1);
    endtask

    task automatic t_clear();
        cfg_write(2'd2, 16'h0004);
        read_cnt("R5", 3'd2, 0);
        chk("R5", "ovf cleared", int'(ovf_map), 0);
        step(1);
        chk("R5", "smi dropped", int'(smi_irq), 0);
    endtask

    task automatic t_clear_race();
        ce_pulse(3'd5);
        ce_pulse(3'd5);
        read_cnt("R6", 3'd5, 2);
        ce_valid = 1'b1; ce_dimm = 3'd5;
        cfg_wr_en = 1'b1; cfg_addr = 2'd2; cfg_wdata = 16'h0020;
        @(negedge clk);
        ce_valid = 1'b0; cfg_wr_en = 1'b0;
        read_cnt("R6", 3'd5, 0);
        step(1);
        read_cnt("R6", 3'd5, 1);
        cfg_write(2'd2, 16'h0020);
    endtask

    task automatic t_redund();
        ue_pulse(3'd6);
        chk("R7", "flag set", int'(redund_lost), 1);
        chk("R7", "failed index", int'(failed_dimm), 6);
        step(1);
        chk("R9", "smi from loss", int'(smi_irq), 1);
        chk("R9", "nmi low", int'(nmi_irq), 0);
    endtask

    task automatic t_both();
        cfg_write(2'd0, 16'd1);
        ce_pulse(3'd1);
        ce_pulse(3'd1);
        step(2);
        chk("R10", "both causes ovf", int'(ovf_map), 8'h02);
        cfg_write(2'd3, 16'h0001);
        chk("R8", "flag cleared", int'(redund_lost), 0);
        step(2);
        chk("R10", "smi still high", int'(smi_irq), 1);
        cfg_write(2'd2, 16'h0002);
        step(1);
        chk("R10", "smi low after both", int'(smi_irq), 0);
    endtask

    task automatic t_w1c_race();
        ue_mirror_valid = 1'b1; ue_dimm = 3'd3;
        cfg_wr_en = 1'b1; cfg_addr = 2'd3; cfg_wdata = 16'h0001;
        @(negedge clk);
        ue_mirror_valid = 1'b0; cfg_wr_en = 1'b0;
        chk("R8", "event wins over clear", int'(redund_lost), 1);
        chk("R7", "failed index 3", int'(failed_dimm), 3);
        cfg_write(2'd3, 16'h0001);
        chk("R8", "flag cleared", int'(redund_lost), 0);
        step(1);
    endtask

    task automatic t_enables();
        cfg_write(2'd1, 16'd0);
        ue_pulse(3'd0);
        step(2);
        chk("R11", "smi disabled", int'(smi_irq), 0);
        chk("R11", "nmi disabled", int'(nmi_irq), 0);
        cfg_write(2'd1, 16'd2);
        step(1);
        chk("R11", "nmi after enable", int'(nmi_irq), 1);
        chk("R11", "smi still low", int'(smi_irq), 0);
        cfg_write(2'd1, 16'd3);
        step(1);
        chk("R9", "both smi", int'(smi_irq), 1);
        chk("R9", "both nmi", int'(nmi_irq), 1);
        cfg_write(2'd3, 16'h0001);
        step(1);
        chk("R9", "lines drop", int'(smi_irq | nmi_irq), 0);
    endtask

    task automatic t_saturate();
        cfg_write(2'd0, 16'hFFFF);
        ce_valid = 1'b1; ce_dimm = 3'd7;
        step(65540);
        ce_valid = 1'b0;
        read_cnt("R3", 3'd7, 16'hFFFF);
        step(1);
        chk("R3", "no ovf at max threshold", int'(ovf_map), 0);
        cfg_write(2'd0, 16'hFFFE);
        step(1);
        chk("R4", "ovf after lowering", int'(ovf_map), 8'h80);
    endtask

    initial begin
        step(4);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_count();
        t_thresh_raise();
        t_clear();
        t_clear_race();
        t_redund();
        t_both();
        t_w1c_race();
        t_enables();
        t_saturate();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule